// File: doc/BRIEF.md
# Double-buffered PWM timer channel pair

The block is a PWM timer with two compare channels. One free-running up-counter, advanced once every `PRESC_DIV` clocks, counts from zero to a programmable period value and then returns to zero. Each return to zero is a wrap event. Each channel compares the counter against its own compare register. Its pin goes to a chosen pulse level at the wrap and to the opposite level at the compare match, so the compare value sets the pulse width in counter ticks.

Setting the upper mode bit of channel 0 links the two channels into one buffered PWM output on the channel 0 pin. The two compare registers then take turns. After linking, channel 0's register is in control. Writing the idle register makes it the pending source, and the pending source takes control at the next wrap. A write to the register already in control changes the width immediately. While the pair is linked, channel 1's pin is released for general-purpose use and its own control bits are ignored. A flag shows which register currently sets the width.

Software configures the block while the counter is stopped, clears the counter and prescaler through a self-clearing bit, and then clears the stop bit to begin.

Top module: `bufpwm_pair`

## Requirements
- R1: After reset both pins are 0, `active_sel` is 0, `ch1_gpio_en` is 0, the counter is 0 and the stop bit is set. The period register is 0xFFFF, and the compare and channel control registers are 0.
- R2: The interface is a one-cycle write strobe with an address and 16-bit data, and a write lands at the next clock edge. Addresses are: 0 control (bit0 stop, bit1 counter/prescaler clear, which is not stored), 1 period, 2 channel 0 compare, 3 channel 1 compare, 4 channel 0 control, 5 channel 1 control. While running, the counter advances once per `PRESC_DIV` clocks. From the period value (or from 0xFFFF) it wraps to 0.
- R3: While stop is 1 the counter and pins hold. A write to address 0 with bit1 set clears counter and prescaler, and no advance happens in that cycle.
- R4: Channel control bits are [1:0] mode (00 off, 01 unbuffered, 1x on channel 0 links the pair, 1x on channel 1 acts as 01), [2] toggle-on-wrap and [4:3] edge/level. In unbuffered use the pin takes the pulse level on the tick that brings the count to 0. It takes the opposite level on the tick that brings the count to the compare value, so the pulse lasts compare x `PRESC_DIV` clocks per period.
- R5: Edge/level 10 gives pulse level 1 and clears the pin on compare. 11 gives pulse level 0 and sets the pin on compare. 00 or 01 makes the channel leave its pin unchanged.
- R6: In linked mode channel 0 first uses compare register 0 (`active_sel`=0). A write to either compare register marks it pending, the last write wins, and at each wrap `active_sel` takes the pending selection. A write in the wrap cycle itself counts for that wrap.
- R7: A write to the compare register currently in control changes the pulse width from the next tick on, with no wait for a wrap.
- R8: While linked, `ch1_gpio_en` is 1 and `ch1_out` is held at 0 from the cycle after linking. Writes to channel 1 control have no effect on either pin.
- R9: A compare value of 0 keeps the pin at the inactive level the whole period (compare wins over wrap). A compare value above the period value keeps it at the pulse level.
- R10: With toggle-on-wrap clear, a wrap does not change the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| ch0_out | output | 1 | Channel 0 pin (buffered PWM when linked) |
| ch1_out | output | 1 | Channel 1 pin, held 0 while linked |
| ch1_gpio_en | output | 1 | 1 while channel 1 pin is released |
| active_sel | output | 1 | Compare register in control: 0 = channel 0, 1 = channel 1 |

## Verification
Unbuffered PWM is driven with a middle duty, with both polarities, with a compare of zero, with a compare beyond the period and with toggle-on-wrap cleared. A one-period window count tells width and polarity apart from the 0% and 100% limits. In linked mode, writes go to the idle register, to both registers in the same period and to the register in control. These separate a hand-over at the wrap from last-write-wins and from an immediate update. A behavioural model compared every cycle pins down the wrap cycle of each hand-over, the stop and clear behaviour and the release of channel 1's pin.

// File: rtl/bufpwm_pkg.sv
package bufpwm_pkg;

  localparam int CTL_W = 5;

  typedef struct packed {
    logic [1:0] els;
    logic       tov;
    logic [1:0] mode;
  } ch_ctl_t;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_MOD  = 3'd1,
    A_CMP0 = 3'd2,
    A_CMP1 = 3'd3,
    A_CTL0 = 3'd4,
    A_CTL1 = 3'd5
  } reg_addr_e;

  function automatic logic ch_on(input ch_ctl_t c);
    return |c.mode;
  endfunction

  function automatic logic cmp_acts(input ch_ctl_t c);
    return c.els[1];
  endfunction

  function automatic logic level_on_match(input ch_ctl_t c);
    return c.els[0];
  endfunction

  function automatic logic level_on_wrap(input ch_ctl_t c);
    return ~c.els[0];
  endfunction

  function automatic logic wants_link(input ch_ctl_t c);
    return c.mode[1];
  endfunction

endpackage

// File: rtl/bufpwm_regs.sv
module bufpwm_regs
  import bufpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             stop,
  output logic             clr,
  output logic [CNT_W-1:0] modulo,
  output logic [CNT_W-1:0] cmp0,
  output logic [CNT_W-1:0] cmp1,
  output ch_ctl_t          ctl0,
  output ch_ctl_t          ctl1,
  output logic             wr_cmp0,
  output logic             wr_cmp1,
  output logic             link_next
);

  logic wr_ctrl, wr_mod, wr_ctl0, wr_ctl1;
  ch_ctl_t ctl_wdata;

  assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
  assign wr_mod    = wr_en && (wr_addr == A_MOD);
  assign wr_cmp0   = wr_en && (wr_addr == A_CMP0);
  assign wr_cmp1   = wr_en && (wr_addr == A_CMP1);
  assign wr_ctl0   = wr_en && (wr_addr == A_CTL0);
  assign wr_ctl1   = wr_en && (wr_addr == A_CTL1);
  assign ctl_wdata = ch_ctl_t'(wr_data[CTL_W-1:0]);
  assign clr       = wr_ctrl && wr_data[1];
  assign link_next = wr_ctl0 ? wants_link(ctl_wdata) : wants_link(ctl0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop   <= 1'b1;
      modulo <= '1;
      cmp0   <= '0;
      cmp1   <= '0;
      ctl0   <= '0;
      ctl1   <= '0;
    end else begin
      if (wr_ctrl) stop   <= wr_data[0];
      if (wr_mod)  modulo <= wr_data;
      if (wr_cmp0) cmp0   <= wr_data;
      if (wr_cmp1) cmp1   <= wr_data;
      if (wr_ctl0) ctl0   <= ctl_wdata;
      if (wr_ctl1) ctl1   <= ctl_wdata;
    end
  end

  // R2: a stored write appears at the next edge
  a_r2_mod_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mod |=> (modulo == $past(wr_data)));

  // R3: the clear bit is never stored as a stop change unless bit0 says so
  a_r3_stop_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (stop == $past(wr_data[0])));

endmodule

// File: rtl/bufpwm_counter.sv
module bufpwm_counter #(
  parameter int CNT_W     = 16,
  parameter int PRESC_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop,
  input  logic             clr,
  input  logic [CNT_W-1:0] modulo,
  output logic             tick,
  output logic             wrap,
  output logic [CNT_W-1:0] cnt_next,
  output logic [CNT_W-1:0] cnt
);

  localparam int PS_W = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic at_end(input logic [CNT_W-1:0] c,
                                  input logic [CNT_W-1:0] m);
    return (c == m) || (c == CNT_MAX);
  endfunction

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic [CNT_W-1:0] m);
    return at_end(c, m) ? '0 : c + 1'b1;
  endfunction

  logic presc_last;
  logic end_hit;

  generate
    if (PRESC_DIV > 1) begin : g_presc
      logic [PS_W-1:0] presc;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      presc <= '0;
        else if (clr)    presc <= '0;
        else if (!stop)  presc <= presc_last ? '0 : presc + 1'b1;
      end
      assign presc_last = (presc == PS_W'(PRESC_DIV - 1));
    end else begin : g_nopresc
      assign presc_last = 1'b1;
    end
  endgenerate

  assign tick     = !stop && !clr && presc_last;
  assign end_hit  = at_end(cnt, modulo);
  assign wrap     = tick && end_hit;
  assign cnt_next = step(cnt, modulo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= cnt_next;
  end

  // R2: a wrap brings the count back to zero
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  // R2: a tick without wrap advances by one
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> (cnt == $past(cnt) + 1'b1));

  // R3: stopped counter holds
  a_r3_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !clr) |=> $stable(cnt));

  // R3: clear empties the counter
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

endmodule

// File: rtl/bufpwm_select.sv
module bufpwm_select (
  input  logic clk,
  input  logic rst_n,
  input  logic linked,
  input  logic link_next,
  input  logic wr_cmp0,
  input  logic wr_cmp1,
  input  logic wrap,
  output logic active,
  output logic sel_eff
);

  logic pend;
  logic pend_eff;

  always_comb begin
    pend_eff = pend;
    if (linked && wr_cmp1)      pend_eff = 1'b1;
    else if (linked && wr_cmp0) pend_eff = 1'b0;
  end

  assign sel_eff = wrap ? pend_eff : active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pend   <= 1'b0;
    end else if (!link_next) begin
      active <= 1'b0;
      pend   <= 1'b0;
    end else begin
      pend <= pend_eff;
      if (wrap) active <= pend_eff;
    end
  end

  // R6: control changes hands only at a wrap
  a_r6_hold_between_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && link_next) |=> $stable(active));

  // R6: unlinked pair always reports channel 0
  a_r6_unlinked_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    !linked |-> !active);

  // R6: a channel 1 write in the wrap cycle takes effect at that wrap
  a_r6_wrap_write_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && linked && link_next && wr_cmp1) |=> active);

endmodule

// File: rtl/bufpwm_chan.sv
module bufpwm_chan
  import bufpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic [CNT_W-1:0] cmp,
  input  ch_ctl_t          ctl,
  input  logic             force_off,
  output logic             out
);

  logic live;
  logic hit;

  assign live = tick && ch_on(ctl) && cmp_acts(ctl);
  assign hit  = (cnt_next == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    out <= 1'b0;
    else if (force_off)            out <= 1'b0;
    else if (live && hit)          out <= level_on_match(ctl);
    else if (live && wrap && ctl.tov) out <= level_on_wrap(ctl);
  end

  // R8: a released pin reads 0
  a_r8_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> !out);

  // R9: compare at count 0 beats the wrap action
  a_r9_compare_beats_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (live && wrap && hit && !force_off) |=> (out == $past(ctl.els[0])));

  // R10: wrap without toggle leaves the pin
  a_r10_no_tov_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wrap && !hit && !ctl.tov && !force_off) |=> $stable(out));

  // R5: edge/level 0x takes no pin action
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_off && !ctl.els[1]) |=> $stable(out));

endmodule

// File: rtl/bufpwm_pair.sv
module bufpwm_pair
  import bufpwm_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PRESC_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             ch0_out,
  output logic             ch1_out,
  output logic             ch1_gpio_en,
  output logic             active_sel
);

  localparam int NCH = 2;

  logic             stop, clr, wr_cmp0, wr_cmp1, link_next;
  logic [CNT_W-1:0] modulo, cmp0, cmp1;
  ch_ctl_t          ctl0, ctl1;
  logic             tick, wrap;
  logic [CNT_W-1:0] cnt_next, cnt;
  logic             linked, sel_eff;

  logic [CNT_W-1:0] ch_cmp   [NCH];
  ch_ctl_t          ch_ctl   [NCH];
  logic             ch_force [NCH];
  logic             ch_pin   [NCH];

  bufpwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stop(stop), .clr(clr), .modulo(modulo),
    .cmp0(cmp0), .cmp1(cmp1), .ctl0(ctl0), .ctl1(ctl1),
    .wr_cmp0(wr_cmp0), .wr_cmp1(wr_cmp1), .link_next(link_next)
  );

  bufpwm_counter #(.CNT_W(CNT_W), .PRESC_DIV(PRESC_DIV)) u_cnt (
    .clk(clk), .rst_n(rst_n), .stop(stop), .clr(clr), .modulo(modulo),
    .tick(tick), .wrap(wrap), .cnt_next(cnt_next), .cnt(cnt)
  );

  assign linked = wants_link(ctl0);

  bufpwm_select u_sel (
    .clk(clk), .rst_n(rst_n), .linked(linked), .link_next(link_next),
    .wr_cmp0(wr_cmp0), .wr_cmp1(wr_cmp1), .wrap(wrap),
    .active(active_sel), .sel_eff(sel_eff)
  );

  assign ch_cmp[0]   = (linked && sel_eff) ? cmp1 : cmp0;
  assign ch_cmp[1]   = cmp1;
  assign ch_ctl[0]   = ctl0;
  assign ch_ctl[1]   = ctl1;
  assign ch_force[0] = 1'b0;
  assign ch_force[1] = linked;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      bufpwm_chan #(.CNT_W(CNT_W)) u_ch (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap),
        .cnt_next(cnt_next), .cmp(ch_cmp[i]), .ctl(ch_ctl[i]),
        .force_off(ch_force[i]), .out(ch_pin[i])
      );
    end
  endgenerate

  assign ch0_out     = ch_pin[0];
  assign ch1_out     = ch_pin[1];
  assign ch1_gpio_en = linked;

  // R1: after reset the counter idles at zero until started
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && $past(cnt) == '0) |-> (cnt == '0));

endmodule

// File: tb/bufpwm_pair_tb.sv
module bufpwm_pair_tb;

  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ch0_out, ch1_out, ch1_gpio_en, active_sel;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;
  string cur = "R1";

  always #2 clk = ~clk;

  bufpwm_pair #(.CNT_W(16), .PRESC_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ch0_out(ch0_out), .ch1_out(ch1_out),
    .ch1_gpio_en(ch1_gpio_en), .active_sel(active_sel)
  );

  // behavioural reference model
  int m_stop, m_mod, m_cmp0, m_cmp1, m_presc, m_cnt, m_pend, m_act;
  bit [4:0] m_c0, m_c1;
  bit m_o0, m_o1;

  function automatic bit pin_step(bit o, bit [4:0] c, bit tk, bit wr, int nx, int cv);
    if (!tk || c[1:0] == 2'b00 || !c[4]) return o;
    if (nx == cv) return c[3];
    if (wr && c[2]) return !c[3];
    return o;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stop = 1; m_mod = 65535; m_cmp0 = 0; m_cmp1 = 0;
      m_presc = 0; m_cnt = 0; m_pend = 0; m_act = 0;
      m_c0 = 0; m_c1 = 0; m_o0 = 0; m_o1 = 0;
    end else begin
      bit clrv, tk, endv, wrv, lk, lkn;
      int nx, pe, sel, cv;
      clrv = wr_en && wr_addr == 0 && wr_data[1];
      tk   = !m_stop && !clrv && (m_presc == DIV - 1);
      if (clrv) m_presc = 0;
      else if (!m_stop) m_presc = (m_presc == DIV - 1) ? 0 : m_presc + 1;
      endv = (m_cnt == m_mod) || (m_cnt == 65535);
      nx   = endv ? 0 : m_cnt + 1;
      wrv  = tk && endv;
      lk   = m_c0[1];
      pe   = m_pend;
      if (lk && wr_en && wr_addr == 3) pe = 1;
      else if (lk && wr_en && wr_addr == 2) pe = 0;
      sel = wrv ? pe : m_act;
      cv  = (lk && sel == 1) ? m_cmp1 : m_cmp0;
      m_o0 = pin_step(m_o0, m_c0, tk, wrv, nx, cv);
      m_o1 = lk ? 1'b0 : pin_step(m_o1, m_c1, tk, wrv, nx, m_cmp1);
      if (clrv) m_cnt = 0; else if (tk) m_cnt = nx;
      lkn = (wr_en && wr_addr == 4) ? wr_data[1] : lk;
      if (!lkn) begin m_pend = 0; m_act = 0; end
      else begin m_pend = pe; if (wrv) m_act = pe; end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_stop = wr_data[0];
          3'd1: m_mod  = wr_data;
          3'd2: m_cmp0 = wr_data;
          3'd3: m_cmp1 = wr_data;
          3'd4: m_c0   = wr_data[4:0];
          3'd5: m_c1   = wr_data[4:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp, string what);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare with the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int a, e;
      a = {ch0_out, ch1_out, ch1_gpio_en, active_sel};
      e = {m_o0, m_o1, m_c0[1], m_act[0]};
      check(a == e, cur, a, e, "model {ch0,ch1,gpio,active}");
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic duty0(input int n, output int hi);
    hi = 0;
    repeat (n) begin @(negedge clk); hi += int'(ch0_out); end
  endtask

  task automatic duty1(input int n, output int hi);
    hi = 0;
    repeat (n) begin @(negedge clk); hi += int'(ch1_out); end
  endtask

  localparam int PER = 10 * DIV;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int hi;
    bit p;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    cur = "R1";
    check({ch0_out, ch1_out, ch1_gpio_en, active_sel} == 0, "R1",
          {ch0_out, ch1_out, ch1_gpio_en, active_sel}, 0, "reset outputs");

    cur = "R4";
    wr(1, 9); wr(2, 4); wr(4, 5'h15); wr(0, 3); wr(0, 0);
    idle(3 * PER); duty0(PER, hi);
    check(hi == 4 * DIV, "R4", hi, 4 * DIV, "unbuffered duty");

    cur = "R5";
    wr(4, 5'h1D); idle(2 * PER); duty0(PER, hi);
    check(hi == PER - 4 * DIV, "R5", hi, PER - 4 * DIV, "set-on-compare duty");
    wr(4, 5'h05); idle(2); duty0(PER, hi);
    check(hi == 0 || hi == PER, "R5", hi, 0, "edge/level 00 holds pin");

    cur = "R9";
    wr(4, 5'h15); wr(2, 0); idle(2 * PER); duty0(PER, hi);
    check(hi == 0, "R9", hi, 0, "zero compare duty");
    wr(2, 12); idle(2 * PER); duty0(PER, hi);
    check(hi == PER, "R9", hi, PER, "compare above period duty");

    cur = "R10";
    wr(2, 4); wr(4, 5'h11); idle(2 * PER); duty0(PER, hi);
    check(hi == 0, "R10", hi, 0, "no toggle on wrap");

    cur = "R4";
    wr(5, 5'h15); wr(3, 6); idle(2 * PER); duty1(PER, hi);
    check(hi == 6 * DIV, "R4", hi, 6 * DIV, "channel 1 unbuffered duty");

    cur = "R6";
    wr(2, 2); wr(4, 5'h16); idle(2);
    cur = "R8";
    check(ch1_gpio_en == 1'b1 && ch1_out == 1'b0, "R8", {ch1_gpio_en, ch1_out}, 2,
          "pin released on link");
    wr(5, 5'h1D); duty1(PER, hi);
    check(hi == 0, "R8", hi, 0, "channel 1 control ignored while linked");
    cur = "R6";
    idle(PER); duty0(PER, hi);
    check(hi == 2 * DIV && active_sel == 1'b0, "R6", hi, 2 * DIV, "linked starts on ch0");
    wr(3, 6); idle(2 * PER); duty0(PER, hi);
    check(active_sel == 1'b1, "R6", active_sel, 1, "hand-over to ch1");
    check(hi == 6 * DIV, "R6", hi, 6 * DIV, "ch1 width after hand-over");
    wr(2, 3); wr(3, 7); idle(2 * PER); duty0(PER, hi);
    check(active_sel == 1'b1 && hi == 7 * DIV, "R6", hi, 7 * DIV, "last write wins");

    cur = "R7";
    wr(3, 5); idle(PER); duty0(PER, hi);
    check(active_sel == 1'b1 && hi == 5 * DIV, "R7", hi, 5 * DIV, "active register write");

    cur = "R6";
    wr(2, 1); idle(2 * PER); duty0(PER, hi);
    check(active_sel == 1'b0 && hi == DIV, "R6", hi, DIV, "hand-back to ch0");

    cur = "R3";
    wr(0, 1); idle(2); p = ch0_out;
    for (int i = 0; i < 3 * PER; i++) begin
      @(negedge clk);
      if (ch0_out != p) begin
        check(1'b0, "R3", ch0_out, p, "pin moved while stopped");
        break;
      end
    end
    check(ch0_out == p, "R3", ch0_out, p, "pin held while stopped");
    wr(0, 3); wr(0, 0);
    cur = "R2";
    wr(1, 4); idle(3 * PER); duty0(5 * DIV, hi);
    check(hi == DIV, "R2", hi, DIV, "shorter period duty");

    idle(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule